// File: doc/BRIEF.md
# Falling-Edge Pulse Capture Latches

This block watches two asynchronous input pins, the top and bottom lines of a four-bit input group, for low-going pulses that are too short or too infrequent to be caught by polling. Each watched pin has a sticky capture flag. The flag is set when the pin falls and then stays low for a programmable number of instruction-cycle enables, which is two by default. A short glitch does not set it.

A latched-read command presents a four-bit word built from the two flags, the level of a clock pin that may be configured as a general input, and a constant zero. The flags are cleared on the clock edge that ends the read, so they are ready for the next pulse. A separate raw view gives the synchronised levels of all four input pins. The capture flags deliberately have no reset, so a pulse seen before a reset is still reported after it.

All pins pass through a synchroniser before any decision is made. The instruction-cycle enable is a strobe supplied by the surrounding core.

Top module: `edge_pulse_catch`

## Requirements
- R1: A watched pin's flag is set on the clock edge where the second (MIN_LOW_CYC-th) instruction-cycle enable is seen with the synchronised pin still low after its falling edge. Clocks without an enable do not count.
- R2: A pin that returns high before that enable is counted leaves its flag clear.
- R3: In the latched-read word, bit 3 is the flag of in_pins[3] and bit 0 is the flag of in_pins[0].
- R4: Bit 1 of the latched-read word is always 0.
- R5: Bit 2 of the latched-read word is the synchronised clk_pin level when cko_is_input is 1, and reads 1 when cko_is_input is 0.
- R6: A clock edge with rd_latched high clears both flags.
- R7: If a flag is set on the same edge as a read, it stays set after that edge.
- R8: Reset does not change the flags. While rst is high, raw_nib reads 4'b1111.
- R9: raw_nib shows in_pins[3:0] two clock edges after a pin change.
- R10: A flag stays set until a read clears it. A pin that stays low after its flag is cleared does not set the flag again until the pin has gone high and fallen again.
- R11: Pulses on in_pins[2:1] have no effect on the latched-read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (the flags are not reset) |
| cyc_en | input | 1 | Instruction-cycle enable strobe |
| in_pins | input | 4 | Asynchronous general input pins |
| clk_pin | input | 1 | Asynchronous clock-pin level, used when configured as an input |
| cko_is_input | input | 1 | Static option: 1 when the clock pin is a general input |
| rd_latched | input | 1 | Latched-read command; clears both flags at the clock edge |
| latched_nib | output | 4 | {flag3, clock-pin bit, 0, flag0} |
| raw_nib | output | 4 | Synchronised in_pins levels |

## Verification
A pin change reaches raw_nib and the clock-pin bit after two clock edges. A falling edge is recognised one edge after that. The flag then rises on the edge that carries the counted enable that completes the minimum low width. With the enable held high, a pulse three clocks long is therefore the shortest that sets a flag, and a pulse two clocks long is the longest that is rejected.

A read clears the flags on the edge at which rd_latched is high, while latched_nib is combinational from the flags. The bench therefore drives inputs on falling clock edges and samples at the next falling edge, so that each check sees exactly the edges counted above. The vector table pads each case with idle cycles beyond the longest path before it samples.

// File: rtl/epc_pkg.sv
package epc_pkg;

    localparam int unsigned PIN_W  = 4;
    localparam int unsigned CAP_N  = 2;
    localparam int unsigned HI_PIN = 3;
    localparam int unsigned LO_PIN = 0;

    typedef enum logic [1:0] {
        QS_IDLE   = 2'd0,
        QS_TIMING = 2'd1,
        QS_HELD   = 2'd2
    } qual_state_e;

    // Bit order of this struct is the read layout: [3] hi flag, [2] clock pin, [1] zero, [0] lo flag
    typedef struct packed {
        logic hi_cap;
        logic cko_bit;
        logic zero_bit;
        logic lo_cap;
    } latched_word_t;

    function automatic latched_word_t pack_word(input logic hi, input logic lo,
                                                input logic cko_sel, input logic cko_lvl);
        latched_word_t w;
        w.hi_cap   = hi;
        w.cko_bit  = cko_sel ? cko_lvl : 1'b1;
        w.zero_bit = 1'b0;
        w.lo_cap   = lo;
        return w;
    endfunction

endpackage

// File: rtl/epc_sync.sv
module epc_sync #(
    parameter int unsigned W       = 5,
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) st[i] <= {W{RST_VAL}};
        end else begin
            st[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/epc_channel.sv
module epc_channel
    import epc_pkg::*;
#(
    parameter int unsigned MIN_LOW_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_en,
    input  logic pin_s,
    input  logic rd_clr,
    output logic latch_q
);
    localparam int unsigned CNT_W = ($clog2(MIN_LOW_CYC) > 0) ? $clog2(MIN_LOW_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MIN_LOW_CYC - 1);

    qual_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             pin_d;
    logic             set_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= QS_IDLE;
            cnt   <= '0;
            pin_d <= 1'b1;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            pin_d <= pin_s;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        set_now = 1'b0;
        unique case (state)
            QS_IDLE: begin
                if (!pin_s && pin_d) begin
                    state_n = QS_TIMING;
                    cnt_n   = '0;
                end
            end
            QS_TIMING: begin
                if (pin_s) begin
                    state_n = QS_IDLE;
                end else if (cyc_en) begin
                    if (cnt == LAST_CNT) begin
                        set_now = 1'b1;
                        state_n = QS_HELD;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            QS_HELD: begin
                if (pin_s) state_n = QS_IDLE;
            end
            default: state_n = QS_IDLE;
        endcase
    end

    // Capture flag: deliberately outside reset; set wins over clear
    always_ff @(posedge clk) begin
        if (set_now)     latch_q <= 1'b1;
        else if (rd_clr) latch_q <= 1'b0;
    end

    p_rise_needs_low_r1: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !$past(latch_q)) |-> !$past(pin_s));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_clr) && !$past(set_now)) |-> !latch_q);

    p_set_beats_read_r7: assert property (@(posedge clk) disable iff (rst)
        $past(set_now) |-> latch_q);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(latch_q) && !$past(rd_clr)) |-> latch_q);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_CNT);
endmodule

// File: rtl/epc_pack.sv
module epc_pack
    import epc_pkg::*;
(
    input  logic       hi_cap,
    input  logic       lo_cap,
    input  logic       cko_sel,
    input  logic       cko_lvl,
    output logic [3:0] nib
);
    latched_word_t w;
    always_comb w = pack_word(hi_cap, lo_cap, cko_sel, cko_lvl);
    assign nib = w;
endmodule

// File: rtl/edge_pulse_catch.sv
module edge_pulse_catch
    import epc_pkg::*;
#(
    parameter int unsigned MIN_LOW_CYC = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_en,
    input  logic [3:0] in_pins,
    input  logic       clk_pin,
    input  logic       cko_is_input,
    input  logic       rd_latched,
    output logic [3:0] latched_nib,
    output logic [3:0] raw_nib
);
    localparam int unsigned SYNC_W = PIN_W + 1;

    logic [SYNC_W-1:0] sync_q;
    logic [CAP_N-1:0]  cap;

    epc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({clk_pin, in_pins}),
        .q   (sync_q)
    );

    assign raw_nib = sync_q[PIN_W-1:0];

    for (genvar g = 0; g < int'(CAP_N); g++) begin : g_chan
        localparam int unsigned PIDX = (g == 0) ? LO_PIN : HI_PIN;
        epc_channel #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .cyc_en  (cyc_en),
            .pin_s   (sync_q[PIDX]),
            .rd_clr  (rd_latched),
            .latch_q (cap[g])
        );
    end

    epc_pack u_pack (
        .hi_cap  (cap[1]),
        .lo_cap  (cap[0]),
        .cko_sel (cko_is_input),
        .cko_lvl (sync_q[PIN_W]),
        .nib     (latched_nib)
    );
endmodule

// File: tb/tb_edge_pulse_catch.sv
module tb_edge_pulse_catch;
    logic       clk = 1'b0;
    logic       rst;
    logic       cyc_en;
    logic [3:0] in_pins;
    logic       clk_pin;
    logic       cko_is_input;
    logic       rd_latched;
    logic [3:0] latched_nib;
    logic [3:0] raw_nib;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    edge_pulse_catch dut (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .in_pins(in_pins),
        .clk_pin(clk_pin), .cko_is_input(cko_is_input), .rd_latched(rd_latched),
        .latched_nib(latched_nib), .raw_nib(raw_nib)
    );

    // {low clocks on pin3, low clocks on pin0, low clocks on pins 2:1, expected word}
    localparam int NV = 8;
    localparam logic [27:0] VEC [NV] = '{
        {8'd1, 8'd0, 8'd0, 4'b0100},
        {8'd2, 8'd0, 8'd0, 4'b0100},
        {8'd3, 8'd0, 8'd0, 4'b1100},
        {8'd0, 8'd3, 8'd0, 4'b0101},
        {8'd3, 8'd3, 8'd0, 4'b1101},
        {8'd6, 8'd2, 8'd0, 4'b1100},
        {8'd2, 8'd9, 8'd0, 4'b0101},
        {8'd0, 8'd0, 8'd8, 4'b0100}
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd_latched = 1'b1;
        tick(1);
        rd_latched = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cyc_en = 1'b0; in_pins = 4'b1111; clk_pin = 1'b0;
        cko_is_input = 1'b0; rd_latched = 1'b0;
        tick(3);
        check("R8 raw in reset", raw_nib, 4'b1111);
        check("R4 bit1 in reset", {3'b000, latched_nib[1]}, 4'b0000);
        check("R5 bit2 with option off", {3'b000, latched_nib[2]}, 4'b0001);
        rst = 1'b0;
        tick(3);
        do_read();
        check("R6 initial clear", latched_nib, 4'b0100);

        // Vector table; cyc_en held high
        cyc_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 16; i++) begin
                in_pins[3] = !(i < int'(VEC[v][27:20]));
                in_pins[0] = !(i < int'(VEC[v][19:12]));
                in_pins[2] = !(i < int'(VEC[v][11:4]));
                in_pins[1] = !(i < int'(VEC[v][11:4]));
                tick(1);
            end
            tick(4);
            check($sformatf("R1 R2 R3 R4 R11 vector %0d", v), latched_nib, VEC[v][3:0]);
            do_read();
            check($sformatf("R6 clear after vector %0d", v), latched_nib, 4'b0100);
        end

        // R1: only enables count, not clocks
        cyc_en = 1'b0;
        in_pins = 4'b1110;
        tick(8);
        check("R1 no enables", latched_nib, 4'b0100);
        cyc_en = 1'b1; tick(1); cyc_en = 1'b0;
        check("R1 one enable", latched_nib, 4'b0100);
        cyc_en = 1'b1; tick(1); cyc_en = 1'b0;
        check("R1 second enable sets", latched_nib, 4'b0101);

        // R10: held low after clear does not re-arm
        do_read();
        check("R6 clear while low", latched_nib, 4'b0100);
        cyc_en = 1'b1;
        tick(6);
        check("R10 no re-set while held low", latched_nib, 4'b0100);
        in_pins = 4'b1111;
        tick(4);
        in_pins = 4'b1110;
        tick(6);
        check("R10 new fall sets again", latched_nib, 4'b0101);

        // R7: set and read on the same edge
        cyc_en = 1'b0;
        in_pins = 4'b0110;
        tick(5);
        cyc_en = 1'b1; tick(1); cyc_en = 1'b0;
        check("R10 partial count", latched_nib, 4'b0100 | 4'b0001);
        cyc_en = 1'b1; rd_latched = 1'b1;
        tick(1);
        cyc_en = 1'b0; rd_latched = 1'b0;
        check("R7 set wins over read", latched_nib, 4'b1100);

        // R8: flags survive reset
        in_pins = 4'b1111;
        tick(3);
        rst = 1'b1;
        in_pins = 4'b0101;
        tick(4);
        check("R8 raw forced in reset", raw_nib, 4'b1111);
        in_pins = 4'b1111;
        tick(1);
        rst = 1'b0;
        tick(4);
        check("R8 flag kept through reset", latched_nib, 4'b1100);
        do_read();

        // R5: clock-pin bit
        cko_is_input = 1'b1; clk_pin = 1'b0;
        tick(3);
        check("R5 clock pin low", latched_nib, 4'b0000);
        clk_pin = 1'b1;
        tick(3);
        check("R5 clock pin high", latched_nib, 4'b0100);
        cko_is_input = 1'b0; clk_pin = 1'b0;
        tick(3);
        check("R5 option off reads 1", latched_nib, 4'b0100);

        // R9: raw latency
        in_pins = 4'b1010;
        tick(1);
        check("R9 raw after one edge", raw_nib, 4'b1111);
        tick(1);
        check("R9 raw after two edges", raw_nib, 4'b1010);
        in_pins = 4'b0101;
        tick(2);
        check("R9 raw second pattern", raw_nib, 4'b0101);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule